// File: doc/BRIEF.md
# Prioritised Voice Interrupt Selector

The block holds the pending interrupts of a bank of synthesis voices in two independent sets: one for voices whose sample playback reached its end, and one for voices whose volume ramp finished. The voice engine raises a one-cycle set pulse per voice and per source. Each time the host writes the dequeue code 0x8F into the function-select register, the block picks one pending source and clears it. It then stores an 8-bit result code that the host reads back through the same function number.

A wave-end voice always wins over a volume-ramp voice. Inside a source, the lowest voice index is served first. The block sends a one-cycle clear strobe for the served voice so the voice engine can drop bit 7 of that voice's control register. It keeps two summary bits in the shared interrupt-status byte and drives the interrupt line while any bit of that byte is set. A write to the reset register with its run bit low empties both sets.

Top module: `voice_irq_dequeue`

## Requirements
- R1: Only a function-select write whose data is exactly 0x8F starts a dequeue. Any other written value leaves `result_o`, both pending sets and both strobes unchanged.
- R2: While any wave-end voice is pending, a dequeue serves a wave-end voice and no volume-ramp voice.
- R3: Within one source, the pending voice with the lowest index (0 up to NUM_VOICES-1) is served.
- R4: Serving wave-end voice v clears its pending bit. In the cycle after the write, it pulses `wave_clr_o[v]` for exactly one cycle and sets `result_o` to 0x60|v (bits 7..5 = 011, bits 4..0 = v).
- R5: Serving volume-ramp voice v clears its pending bit. In the cycle after the write, it pulses `ramp_clr_o[v]` for one cycle and sets `result_o` to 0x80|v (bits 7..5 = 100).
- R6: A dequeue with both sets empty sets `result_o` to 0xE8 and raises no clear strobe.
- R7: Status bit 5 (wave-end summary) clears when a dequeue empties the wave-end set. Status bit 6 (ramp summary) clears when a dequeue empties the ramp set. Neither clears while its set is still non-empty.
- R8: `irq_status_o` is `other_irq_i` OR'd with the two summary bits at positions 5 and 6. `irq_o` is high exactly when that byte is non-zero.
- R9: A reset-register write with `rst_reg_run_i` low empties both pending sets and clears both summary bits. The same write with `rst_reg_run_i` high changes nothing.
- R10: A set pulse for a voice in the same cycle as that voice's dequeue clear leaves the voice pending. It is served again on a later dequeue.
- R11: A set pulse for either source sets the matching summary bit (5 or 6) one cycle later, which raises `irq_o`.
- R12: After reset, `result_o` is 0xE8, both sets and summary bits are empty, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wave_set_i | input | NUM_VOICES | Per-voice wave-end pending set pulses |
| ramp_set_i | input | NUM_VOICES | Per-voice volume-ramp pending set pulses |
| fsel_wr_i | input | 1 | Function-select register write strobe |
| fsel_data_i | input | 8 | Function-select write data |
| rst_reg_wr_i | input | 1 | Reset register write strobe |
| rst_reg_run_i | input | 1 | Run bit (bit 0) of the reset register write data |
| other_irq_i | input | 8 | Status bits owned by other interrupt sources |
| result_o | output | 8 | Stored dequeue result code |
| wave_clr_o | output | NUM_VOICES | One-cycle clear strobe for the wave control flag of a voice |
| ramp_clr_o | output | NUM_VOICES | One-cycle clear strobe for the ramp control flag of a voice |
| irq_status_o | output | 8 | Shared interrupt-status byte |
| irq_o | output | 1 | Interrupt-line request |

## Verification
The dequeue is first tried on an empty block, then on a mix of two wave-end voices and one ramp voice. Draining that mix one voice at a time separates source priority from index order and shows each summary bit dropping only on the last voice of its set. A separate run with two ramp voices at indices 30 and 12 checks the ramp code and the upward scan without wave traffic. Non-trigger writes and a reset write with the run bit high are placed between real dequeues to show they change nothing. A set pulse that collides with its own clear, and a flush followed by a dequeue, cover the two corner cases that an order-only model would miss.

// File: rtl/vid_pkg.sv
package vid_pkg;
  localparam int VIDX_W = 5;
  localparam logic [7:0] DEQ_CODE  = 8'h8F;
  localparam logic [7:0] IDLE_CODE = 8'hE8;
  localparam logic [2:0] TAG_WAVE  = 3'b011;
  localparam logic [2:0] TAG_RAMP  = 3'b100;

  typedef enum logic [1:0] {SRC_NONE, SRC_WAVE, SRC_RAMP} src_e;

  function automatic logic [7:0] make_code(src_e src, logic [VIDX_W-1:0] idx);
    case (src)
      SRC_WAVE: make_code = {TAG_WAVE, idx};
      SRC_RAMP: make_code = {TAG_RAMP, idx};
      default:  make_code = IDLE_CODE;
    endcase
  endfunction
endpackage

// File: rtl/vid_pending_bank.sv
module vid_pending_bank #(
  parameter int NUM_VOICES = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VOICES-1:0] set_i,
  input  logic [NUM_VOICES-1:0] clr_i,
  input  logic                  flush_i,
  output logic [NUM_VOICES-1:0] pend_o
);
  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       pend_o[v] <= 1'b0;
      else if (set_i[v])                pend_o[v] <= 1'b1;
      else if (flush_i || clr_i[v])     pend_o[v] <= 1'b0;
    end
  end

  // set pulse wins over a same-cycle clear or flush
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/vid_first_set.sv
module vid_first_set #(
  parameter int NUM_VOICES = 31,
  parameter int IW = 5
) (
  input  logic [NUM_VOICES-1:0] vec_i,
  output logic                  found_o,
  output logic [IW-1:0]         idx_o,
  output logic [NUM_VOICES-1:0] hot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_VOICES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign hot_o   = vec_i & (~vec_i + NUM_VOICES'(1));
  assign found_o = |vec_i;
endmodule

// File: rtl/voice_irq_dequeue.sv
module voice_irq_dequeue
  import vid_pkg::*;
#(
  parameter int NUM_VOICES = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_VOICES-1:0] wave_set_i,
  input  logic [NUM_VOICES-1:0] ramp_set_i,
  input  logic                  fsel_wr_i,
  input  logic [7:0]            fsel_data_i,
  input  logic                  rst_reg_wr_i,
  input  logic                  rst_reg_run_i,
  input  logic [7:0]            other_irq_i,
  output logic [7:0]            result_o,
  output logic [NUM_VOICES-1:0] wave_clr_o,
  output logic [NUM_VOICES-1:0] ramp_clr_o,
  output logic [7:0]            irq_status_o,
  output logic                  irq_o
);
  localparam int IW = VIDX_W;

  logic [NUM_VOICES-1:0] wave_pend, ramp_pend, wave_hot, ramp_hot;
  logic [NUM_VOICES-1:0] wave_clr_mask, ramp_clr_mask;
  logic [IW-1:0]         wave_idx, ramp_idx;
  logic                  wave_found, ramp_found;
  logic                  deq_fire, flush, serve_wave, serve_ramp;
  logic                  wave_left, ramp_left;
  logic                  wave_sum_q, ramp_sum_q;
  src_e                  pick_src;

  // named events
  assign deq_fire   = fsel_wr_i && (fsel_data_i == DEQ_CODE);
  assign flush      = rst_reg_wr_i && !rst_reg_run_i;
  assign serve_wave = deq_fire && wave_found;
  assign serve_ramp = deq_fire && !wave_found && ramp_found;

  vid_first_set #(.NUM_VOICES(NUM_VOICES), .IW(IW)) u_wave_pick (
    .vec_i(wave_pend), .found_o(wave_found), .idx_o(wave_idx), .hot_o(wave_hot));
  vid_first_set #(.NUM_VOICES(NUM_VOICES), .IW(IW)) u_ramp_pick (
    .vec_i(ramp_pend), .found_o(ramp_found), .idx_o(ramp_idx), .hot_o(ramp_hot));

  assign wave_clr_mask = serve_wave ? wave_hot : '0;
  assign ramp_clr_mask = serve_ramp ? ramp_hot : '0;

  vid_pending_bank #(.NUM_VOICES(NUM_VOICES)) u_wave_bank (
    .clk(clk), .rst_n(rst_n), .set_i(wave_set_i), .clr_i(wave_clr_mask),
    .flush_i(flush), .pend_o(wave_pend));
  vid_pending_bank #(.NUM_VOICES(NUM_VOICES)) u_ramp_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ramp_set_i), .clr_i(ramp_clr_mask),
    .flush_i(flush), .pend_o(ramp_pend));

  assign wave_left = (wave_pend & ~wave_hot) != '0;
  assign ramp_left = (ramp_pend & ~ramp_hot) != '0;

  always_comb begin
    if (serve_wave)      pick_src = SRC_WAVE;
    else if (serve_ramp) pick_src = SRC_RAMP;
    else                 pick_src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o   <= IDLE_CODE;
      wave_clr_o <= '0;
      ramp_clr_o <= '0;
      wave_sum_q <= 1'b0;
      ramp_sum_q <= 1'b0;
    end else begin
      wave_clr_o <= wave_clr_mask;
      ramp_clr_o <= ramp_clr_mask;
      if (deq_fire)
        result_o <= make_code(pick_src, serve_wave ? wave_idx : ramp_idx);
      if (wave_set_i != '0)              wave_sum_q <= 1'b1;
      else if (flush)                    wave_sum_q <= 1'b0;
      else if (serve_wave && !wave_left) wave_sum_q <= 1'b0;
      if (ramp_set_i != '0)              ramp_sum_q <= 1'b1;
      else if (flush)                    ramp_sum_q <= 1'b0;
      else if (serve_ramp && !ramp_left) ramp_sum_q <= 1'b0;
    end
  end

  assign irq_status_o = other_irq_i | {1'b0, ramp_sum_q, wave_sum_q, 5'b0};
  assign irq_o        = irq_status_o != 8'h00;

  // assertions
  assert_no_trigger_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel_wr_i && fsel_data_i != DEQ_CODE) |=> $stable(result_o));
  assert_wave_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_fire && wave_found) |=> (ramp_clr_o == '0 && result_o[7:5] == TAG_WAVE));
  assert_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wave_found |-> ((wave_pend & (wave_hot - NUM_VOICES'(1))) == '0 && (wave_pend & wave_hot) != '0));
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wave_clr_o, ramp_clr_o}));
  assert_ramp_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    serve_ramp |=> (result_o[7:5] == TAG_RAMP && wave_clr_o == '0));
  assert_idle_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_fire && !wave_found && !ramp_found) |=>
      (result_o == IDLE_CODE && wave_clr_o == '0 && ramp_clr_o == '0));
  assert_sum_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wave_found |-> wave_sum_q);
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && wave_set_i == '0 && ramp_set_i == '0) |=>
      (wave_pend == '0 && ramp_pend == '0 && !wave_sum_q && !ramp_sum_q));
  assert_set_raises_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_set_i != '0 || ramp_set_i != '0) |=> irq_o);
endmodule

// File: tb/voice_irq_dequeue_tb_top.sv
module voice_irq_dequeue_tb_top;
  localparam int NV = 31;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NV-1:0] wave_set_i = '0, ramp_set_i = '0;
  logic fsel_wr_i = 1'b0, rst_reg_wr_i = 1'b0, rst_reg_run_i = 1'b1;
  logic [7:0] fsel_data_i = 8'h00, other_irq_i = 8'h00;
  logic [7:0] result_o, irq_status_o;
  logic [NV-1:0] wave_clr_o, ramp_clr_o;
  logic irq_o;

  always #5 clk = ~clk;

  voice_irq_dequeue #(.NUM_VOICES(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wave_set_i(wave_set_i), .ramp_set_i(ramp_set_i),
    .fsel_wr_i(fsel_wr_i), .fsel_data_i(fsel_data_i), .rst_reg_wr_i(rst_reg_wr_i),
    .rst_reg_run_i(rst_reg_run_i), .other_irq_i(other_irq_i), .result_o(result_o),
    .wave_clr_o(wave_clr_o), .ramp_clr_o(ramp_clr_o), .irq_status_o(irq_status_o),
    .irq_o(irq_o));

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0]    res;
    logic [NV-1:0] wclr;
    logic [NV-1:0] rclr;
  } item_t;
  item_t exp_q[$];
  string tag_q[$];

  logic [NV-1:0] wm = '0, rm = '0;   // bench model of the pending sets

  task automatic check(bit ok, string tag, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // monitor: compare one dequeue result per item
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(result_o == e.res, {t, " result"}, result_o, e.res);
      check(wave_clr_o == e.wclr, {t, " wave strobe"}, wave_clr_o, e.wclr);
      check(ramp_clr_o == e.rclr, {t, " ramp strobe"}, ramp_clr_o, e.rclr);
    end
  end

  task automatic pulse(logic [NV-1:0] w, logic [NV-1:0] r);
    wave_set_i = w; ramp_set_i = r;
    @(posedge clk);
    wm |= w; rm |= r;
    @(negedge clk);
    wave_set_i = '0; ramp_set_i = '0;
  endtask

  // driver: dequeue, optionally with a colliding wave set pulse
  task automatic dequeue(string tag, logic [NV-1:0] wcoll);
    item_t e;
    e.res = 8'hE8; e.wclr = '0; e.rclr = '0;
    if (wm != '0) begin
      for (int v = NV - 1; v >= 0; v--) if (wm[v]) begin e.res = 8'h60 | 8'(v); e.wclr = '0; e.wclr[v] = 1'b1; end
    end else if (rm != '0) begin
      for (int v = NV - 1; v >= 0; v--) if (rm[v]) begin e.res = 8'h80 | 8'(v); e.rclr = '0; e.rclr[v] = 1'b1; end
    end
    fsel_wr_i = 1'b1; fsel_data_i = 8'h8F; wave_set_i = wcoll;
    @(posedge clk);
    wm = (wm & ~e.wclr) | wcoll; rm = rm & ~e.rclr;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    fsel_wr_i = 1'b0; wave_set_i = '0;
  endtask

  task automatic fsel_other(logic [7:0] d);
    fsel_wr_i = 1'b1; fsel_data_i = d;
    @(negedge clk);
    fsel_wr_i = 1'b0;
  endtask

  task automatic rst_write(bit run);
    rst_reg_wr_i = 1'b1; rst_reg_run_i = run;
    @(posedge clk);
    if (!run) begin wm = '0; rm = '0; end
    @(negedge clk);
    rst_reg_wr_i = 1'b0; rst_reg_run_i = 1'b1;
  endtask

  task automatic check_sums(string tag, bit w, bit r);
    check(irq_status_o[5] == w, {tag, " wave summary"}, irq_status_o[5], w);
    check(irq_status_o[6] == r, {tag, " ramp summary"}, irq_status_o[6], r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(result_o == 8'hE8, "R12 result", result_o, 8'hE8);
    check(irq_o == 1'b0 && irq_status_o == 8'h00, "R12 irq", irq_status_o, 0);
    check(wave_clr_o == '0 && ramp_clr_o == '0, "R12 strobes", wave_clr_o, 0);
    // R6 empty dequeue
    dequeue("R6 empty", '0);
    @(negedge clk);
    // R11 set pulses
    pulse((NV'(1) << 7) | (NV'(1) << 3), NV'(1));
    check_sums("R11", 1'b1, 1'b1);
    check(irq_o == 1'b1, "R11 irq", irq_o, 1);
    // R1 non-trigger writes
    fsel_other(8'h45);
    fsel_other(8'h0F);
    check(result_o == 8'hE8, "R1 result unchanged", result_o, 8'hE8);
    check(wave_clr_o == '0 && ramp_clr_o == '0, "R1 no strobe", wave_clr_o, 0);
    // R9 run bit high: nothing changes
    rst_write(1'b1);
    check_sums("R9 run high", 1'b1, 1'b1);
    // R2 R3 R4 drain wave set first, lowest index first
    dequeue("R4 R3 R2 wave v3", '0);
    check_sums("R7 wave still pending", 1'b1, 1'b1);
    dequeue("R4 R2 wave v7", '0);
    check_sums("R7 wave emptied", 1'b0, 1'b1);
    // R5 ramp v0
    dequeue("R5 ramp v0", '0);
    check_sums("R7 ramp emptied", 1'b0, 1'b0);
    check(irq_o == 1'b0, "R8 irq released", irq_o, 0);
    dequeue("R6 drained", '0);
    @(negedge clk);
    // R8 other sources
    other_irq_i = 8'h04;
    #1;
    check(irq_o == 1'b1 && irq_status_o == 8'h04, "R8 other bit", irq_status_o, 8'h04);
    other_irq_i = 8'h00;
    #1;
    check(irq_o == 1'b0, "R8 other cleared", irq_o, 0);
    @(negedge clk);
    // R10 collision of set and clear
    pulse(NV'(1) << 30, '0);
    dequeue("R10 first serve v30", NV'(1) << 30);
    check_sums("R10 still pending", 1'b1, 1'b0);
    dequeue("R10 second serve v30", '0);
    dequeue("R10 then empty", '0);
    @(negedge clk);
    // R5 R3 ramp ordering at high indices
    pulse('0, (NV'(1) << 30) | (NV'(1) << 12));
    dequeue("R5 R3 ramp v12", '0);
    dequeue("R5 ramp v30", '0);
    @(negedge clk);
    // R9 flush
    pulse(NV'(1) << 5, NV'(1) << 9);
    rst_write(1'b0);
    check_sums("R9 flush", 1'b0, 1'b0);
    check(irq_o == 1'b0, "R9 irq after flush", irq_o, 0);
    dequeue("R9 empty after flush", '0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule